// File: doc/BRIEF.md
# Two-Port Synchronous Memory with Cross-Port Forwarding

This block is a synchronous memory whose one storage array is shared by two independent ports, X and Y. Each port has its own address, active-low write strobe, active-low forwarding request, write-data input, registered read-data output and output-enable. One clock and two chip-select inputs govern both ports. Addresses, controls, chip selects and write data are captured on the rising edge. Read data reaches the port one edge later, through an output register.

A forwarding request makes the write data captured on one port appear on the other port's output, in place of a read. This lets two agents hand words to each other without a trip through the array. When both ports hit one word in the same cycle, fixed rules apply. A read sees the contents from before any write in that cycle, and port Y's data is kept when both ports write. Pads are modelled as separate data-out and drive-enable signals per port. The drive-enable is the port's output-enable ANDed with a registered valid flag.

Top module: `xy_sram`

## Requirements
- R1: Inputs captured at rising edge n produce the read result on `x_dout`/`y_dout` after edge n+1. After edge n the port still shows the result of the cycle captured at edge n-1.
- R2: The device is selected only when `sel_lo_n` is 0 and `sel_hi` is 1 at the capturing edge. A deselected cycle writes nothing, and it leaves both drive-enables low for the cycle it governs.
- R3: A port writes its data word to the addressed word when its write strobe (`x_wr_n`/`y_wr_n`) is 0 in a selected cycle. A later read returns that word.
- R4: With `x_pass_n` at 0 in a selected cycle, `y_dout` shows the `x_din` captured in that cycle, and `y_drive` is high if `y_oe_n` is 0.
- R5: With `y_pass_n` at 0 in a selected cycle, `x_dout` shows the `y_din` captured in that cycle, and `x_drive` is high if `x_oe_n` is 0.
- R6: Forwarding into a port overrides that port's read. A port whose own forwarding request is 0 does not read.
- R7: Two reads of the same address in one cycle both return the stored word.
- R8: A read on one port and a write on the other to the same address in one cycle return the old contents. The new word is seen from the next cycle on.
- R9: When both ports write the same address in one cycle, only port Y's data is stored.
- R10: `x_oe_n`/`y_oe_n` act without a clock. While a port's output-enable is 1, its drive-enable is 0, in the same cycle.
- R11: A port's drive-enable is low for a cycle whose captured operation on that port is neither a read nor forwarding into it. Such a cycle is a write on that port, or a cycle in which it requests forwarding out.
- R12: After synchronous reset `rst`, both drive-enables are low until a selected read or forwarding cycle completes.
- R13: Writes on both ports and forwarding in both directions can be combined in one cycle. Each port's output shows the other port's input, and both writes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| x_addr | input | ADDR_W | Port X address |
| x_wr_n | input | 1 | Port X write strobe, active low |
| x_pass_n | input | 1 | Forward port X input to port Y output, active low |
| x_din | input | DATA_W | Port X write / forwarding data |
| x_oe_n | input | 1 | Port X output enable, active low, unclocked |
| x_dout | output | DATA_W | Port X registered output data |
| x_drive | output | 1 | Port X pad drive-enable |
| y_addr | input | ADDR_W | Port Y address |
| y_wr_n | input | 1 | Port Y write strobe, active low |
| y_pass_n | input | 1 | Forward port Y input to port X output, active low |
| y_din | input | DATA_W | Port Y write / forwarding data |
| y_oe_n | input | 1 | Port Y output enable, active low, unclocked |
| y_dout | output | DATA_W | Port Y registered output data |
| y_drive | output | 1 | Port Y pad drive-enable |

## Verification
The sharpest overlaps come when both ports touch one word in the same cycle. A read against a write must return the old word, and a write against a write must keep port Y's data. Forwarding can also meet a read on the receiving port, or meet writes on both ports with forwarding in both directions. Each such cycle is driven as one table vector and followed by an idle cycle. The outputs are then judged against hand-computed values, and a later read vector confirms what the array holds.

// File: rtl/xy_sram_pkg.sv
package xy_sram_pkg;

    localparam int DEF_DATA_W = 36;
    localparam int DEF_ADDR_W = 15;
    localparam int DEF_DEPTH  = 512;
    localparam int NPORT      = 2;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_READ    = 2'd1,
        OP_FORWARD = 2'd2
    } out_op_e;

    typedef struct packed {
        logic sel;
        logic wr_n;
        logic pass_n;
    } port_ctl_t;

    // Output operation of one port, given its own controls and the other
    // port's forwarding request (forwarding in beats a read).
    function automatic out_op_e out_op(input logic sel, input port_ctl_t own,
                                       input logic other_pass_n);
        if (!sel)
            return OP_IDLE;
        if (!other_pass_n)
            return OP_FORWARD;
        if (own.wr_n && own.pass_n)
            return OP_READ;
        return OP_IDLE;
    endfunction

    function automatic logic selected(input logic lo_n, input logic hi);
        return !lo_n && hi;
    endfunction

endpackage

// File: rtl/xy_sram_in_reg.sv
module xy_sram_in_reg
    import xy_sram_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              wr_n_d,
    input  logic              pass_n_d,
    input  logic [DATA_W-1:0] din_d,
    output port_ctl_t         ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.sel    <= 1'b0;
            ctl_q.wr_n   <= 1'b1;
            ctl_q.pass_n <= 1'b1;
            addr_q       <= '0;
            din_q        <= '0;
        end else begin
            ctl_q.sel    <= sel_d;
            ctl_q.wr_n   <= wr_n_d;
            ctl_q.pass_n <= pass_n_d;
            addr_q       <= addr_d;
            din_q        <= din_d;
        end
    end

endmodule

// File: rtl/xy_sram_core.sv
module xy_sram_core
    import xy_sram_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic                          clk,
    input  logic [NPORT-1:0]              we,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [NPORT-1:0][IDX_W-1:0] idx;
    logic same_word;
    logic x_blocked;

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_rd
            assign idx[p]   = addr[p][IDX_W-1:0];
            // Combinational read; the output register samples it at the same
            // edge the write lands, so a read sees the pre-write contents.
            assign rdata[p] = mem[idx[p]];
        end
    endgenerate

    assign same_word = (addr[0] == addr[1]);
    assign x_blocked = we[1] && same_word;

    always_ff @(posedge clk) begin
        if (we[0] && !x_blocked)
            mem[idx[0]] <= wdata[0];
        if (we[1])
            mem[idx[1]] <= wdata[1];
    end

endmodule

// File: rtl/xy_sram_out.sv
module xy_sram_out
    import xy_sram_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  out_op_e           op,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] fwd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);

    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dout    <= '0;
        end else begin
            valid_q <= (op != OP_IDLE);
            case (op)
                OP_READ:    dout <= rdata;
                OP_FORWARD: dout <= fwd_data;
                default:    dout <= dout;
            endcase
        end
    end

    assign drive = !oe_n && valid_q;

endmodule

// File: rtl/xy_sram.sv
module xy_sram
    import xy_sram_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic              x_wr_n,
    input  logic              x_pass_n,
    input  logic [DATA_W-1:0] x_din,
    input  logic              x_oe_n,
    output logic [DATA_W-1:0] x_dout,
    output logic              x_drive,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic              y_wr_n,
    input  logic              y_pass_n,
    input  logic [DATA_W-1:0] y_din,
    input  logic              y_oe_n,
    output logic [DATA_W-1:0] y_dout,
    output logic              y_drive
);

    logic sel_d;
    logic [NPORT-1:0][ADDR_W-1:0] addr_d, addr_q;
    logic [NPORT-1:0][DATA_W-1:0] din_d, din_q, rdata, dout;
    logic [NPORT-1:0] wr_n_d, pass_n_d, oe_n, drive, we;
    port_ctl_t [NPORT-1:0] ctl_q;
    out_op_e op [NPORT];

    assign sel_d = selected(sel_lo_n, sel_hi);

    assign addr_d   = {y_addr, x_addr};
    assign din_d    = {y_din, x_din};
    assign wr_n_d   = {y_wr_n, x_wr_n};
    assign pass_n_d = {y_pass_n, x_pass_n};
    assign oe_n     = {y_oe_n, x_oe_n};

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            localparam int OTHER = NPORT - 1 - p;

            xy_sram_in_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_in (
                .clk      (clk),
                .rst      (rst),
                .sel_d    (sel_d),
                .addr_d   (addr_d[p]),
                .wr_n_d   (wr_n_d[p]),
                .pass_n_d (pass_n_d[p]),
                .din_d    (din_d[p]),
                .ctl_q    (ctl_q[p]),
                .addr_q   (addr_q[p]),
                .din_q    (din_q[p])
            );

            assign we[p] = ctl_q[p].sel && !ctl_q[p].wr_n;
            assign op[p] = out_op(ctl_q[p].sel, ctl_q[p], ctl_q[OTHER].pass_n);

            xy_sram_out #(.DATA_W(DATA_W)) u_out (
                .clk      (clk),
                .rst      (rst),
                .op       (op[p]),
                .rdata    (rdata[p]),
                .fwd_data (din_q[OTHER]),
                .oe_n     (oe_n[p]),
                .dout     (dout[p]),
                .drive    (drive[p])
            );
        end
    endgenerate

    xy_sram_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_core (
        .clk   (clk),
        .we    (we),
        .addr  (addr_q),
        .wdata (din_q),
        .rdata (rdata)
    );

    assign x_dout  = dout[0];
    assign y_dout  = dout[1];
    assign x_drive = drive[0];
    assign y_drive = drive[1];

endmodule

// File: rtl/xy_sram_checker.sv
module xy_sram_checker #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_lo_n,
    input logic              sel_hi,
    input logic              x_wr_n,
    input logic              x_pass_n,
    input logic [DATA_W-1:0] x_din,
    input logic              x_oe_n,
    input logic [DATA_W-1:0] x_dout,
    input logic              x_drive,
    input logic              y_wr_n,
    input logic              y_pass_n,
    input logic [DATA_W-1:0] y_din,
    input logic              y_oe_n,
    input logic [DATA_W-1:0] y_dout,
    input logic              y_drive
);

    logic [1:0] since_rst;
    logic       live;
    logic       sel_ok;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    assign live   = (since_rst == 2'd3);
    assign sel_ok = !sel_lo_n && sel_hi;

    AST_OE_GATES_X: assert property (@(posedge clk) disable iff (rst)
        x_oe_n |-> !x_drive); // R10
    AST_OE_GATES_Y: assert property (@(posedge clk) disable iff (rst)
        y_oe_n |-> !y_drive); // R10
    AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!sel_ok, 2)) |-> (!x_drive && !y_drive)); // R2
    AST_WRITE_SILENCES_X: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!x_wr_n && y_pass_n, 2)) |-> !x_drive); // R11
    AST_WRITE_SILENCES_Y: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!y_wr_n && x_pass_n, 2)) |-> !y_drive); // R11
    AST_FORWARD_X_TO_Y: assert property (@(posedge clk) disable iff (rst)
        (live && $past(sel_ok && !x_pass_n, 2) && !y_oe_n)
            |-> (y_drive && y_dout == $past(x_din, 2))); // R4
    AST_FORWARD_Y_TO_X: assert property (@(posedge clk) disable iff (rst)
        (live && $past(sel_ok && !y_pass_n, 2) && !x_oe_n)
            |-> (x_drive && x_dout == $past(y_din, 2))); // R5

endmodule

bind xy_sram xy_sram_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .x_wr_n   (x_wr_n),
    .x_pass_n (x_pass_n),
    .x_din    (x_din),
    .x_oe_n   (x_oe_n),
    .x_dout   (x_dout),
    .x_drive  (x_drive),
    .y_wr_n   (y_wr_n),
    .y_pass_n (y_pass_n),
    .y_din    (y_din),
    .y_oe_n   (y_oe_n),
    .y_dout   (y_dout),
    .y_drive  (y_drive)
);

// File: tb/xy_sram_test.sv
module xy_sram_test;

    localparam int DW = 36;
    localparam int AW = 15;
    localparam int NVEC = 16;

    typedef struct packed {
        logic          lo_n;
        logic          hi;
        logic [AW-1:0] xa;
        logic          xw;
        logic          xp;
        logic [DW-1:0] xd;
        logic [AW-1:0] ya;
        logic          yw;
        logic          yp;
        logic [DW-1:0] yd;
        logic          ex_v;
        logic [DW-1:0] ex_q;
        logic          ey_v;
        logic [DW-1:0] ey_q;
        logic [7:0]    req;
    } vec_t;

    localparam logic [DW-1:0] A1 = 36'h1_2345_6789, B1 = 36'hA_BCDE_F012,
        B2 = 36'h5_5555_AAAA, C1 = 36'h0_F0F0_F0F0, C2 = 36'hF_0F0F_0F0F,
        D1 = 36'h3_1415_9265, D2 = 36'h2_7182_8182, E1 = 36'h8_0000_0001,
        E2 = 36'h7_FFFF_FFFE, F1 = 36'hD_EADB_EEF0, G1 = 36'h6_6666_6666,
        F2 = 36'h9_9999_0000, Z = 36'h0;

    // lo_n hi | xa xw xp xd | ya yw yp yd | ex_v ex_q | ey_v ey_q | req
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b1, 15'd5,1'b0,1'b1,A1, 15'd6,1'b0,1'b1,B1, 1'b0,Z, 1'b0,Z, 8'd11}, // R11 R3 both write
        '{1'b0,1'b1, 15'd6,1'b1,1'b1,Z,  15'd5,1'b1,1'b1,Z,  1'b1,B1,1'b1,A1,8'd3},  // R3 reads back
        '{1'b0,1'b1, 15'd5,1'b1,1'b1,Z,  15'd5,1'b1,1'b1,Z,  1'b1,A1,1'b1,A1,8'd7},  // R7 same-address reads
        '{1'b0,1'b1, 15'd5,1'b1,1'b1,Z,  15'd5,1'b0,1'b1,B2, 1'b1,A1,1'b0,Z, 8'd8},  // R8 read before write
        '{1'b0,1'b1, 15'd5,1'b1,1'b1,Z,  15'd5,1'b1,1'b1,Z,  1'b1,B2,1'b1,B2,8'd8},  // R8 new value after
        '{1'b0,1'b1, 15'd7,1'b0,1'b1,C1, 15'd7,1'b0,1'b1,C2, 1'b0,Z, 1'b0,Z, 8'd9},  // R9 double write
        '{1'b0,1'b1, 15'd7,1'b1,1'b1,Z,  15'd7,1'b1,1'b1,Z,  1'b1,C2,1'b1,C2,8'd9},  // R9 Y kept
        '{1'b0,1'b1, 15'd6,1'b1,1'b0,D1, 15'd5,1'b1,1'b1,Z,  1'b0,Z, 1'b1,D1,8'd4},  // R4 R6 X to Y
        '{1'b0,1'b1, 15'd6,1'b1,1'b1,Z,  15'd5,1'b1,1'b0,D2, 1'b1,D2,1'b0,Z, 8'd5},  // R5 R6 Y to X
        '{1'b0,1'b1, 15'd8,1'b0,1'b0,E1, 15'd9,1'b0,1'b0,E2, 1'b1,E2,1'b1,E1,8'd13}, // R13 all combined
        '{1'b0,1'b1, 15'd8,1'b1,1'b1,Z,  15'd9,1'b1,1'b1,Z,  1'b1,E1,1'b1,E2,8'd13}, // R13 writes stored
        '{1'b1,1'b1, 15'd8,1'b0,1'b1,F1, 15'd8,1'b1,1'b0,F1, 1'b0,Z, 1'b0,Z, 8'd2},  // R2 deselect low-side
        '{1'b0,1'b1, 15'd8,1'b1,1'b1,Z,  15'd8,1'b1,1'b1,Z,  1'b1,E1,1'b1,E1,8'd2},  // R2 no write done
        '{1'b0,1'b1, 15'd9,1'b0,1'b1,G1, 15'd9,1'b1,1'b1,Z,  1'b0,Z, 1'b1,E2,8'd8},  // R8 reversed ports
        '{1'b0,1'b0, 15'd9,1'b0,1'b1,F2, 15'd9,1'b0,1'b1,F2, 1'b0,Z, 1'b0,Z, 8'd2},  // R2 deselect high-side
        '{1'b0,1'b1, 15'd9,1'b1,1'b1,Z,  15'd9,1'b1,1'b1,Z,  1'b1,G1,1'b1,G1,8'd2}   // R2 G1 kept
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_lo_n = 1'b1, sel_hi = 1'b0;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic x_wr_n = 1'b1, x_pass_n = 1'b1, y_wr_n = 1'b1, y_pass_n = 1'b1;
    logic [DW-1:0] x_din = '0, y_din = '0;
    logic x_oe_n = 1'b0, y_oe_n = 1'b0;
    logic [DW-1:0] x_dout, y_dout;
    logic x_drive, y_drive;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xy_sram uut (
        .clk(clk), .rst(rst), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .x_addr(x_addr), .x_wr_n(x_wr_n), .x_pass_n(x_pass_n), .x_din(x_din),
        .x_oe_n(x_oe_n), .x_dout(x_dout), .x_drive(x_drive),
        .y_addr(y_addr), .y_wr_n(y_wr_n), .y_pass_n(y_pass_n), .y_din(y_din),
        .y_oe_n(y_oe_n), .y_dout(y_dout), .y_drive(y_drive)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        sel_lo_n = 1'b0; sel_hi = 1'b1;
        x_addr = '0; x_wr_n = 1'b1; x_pass_n = 1'b1; x_din = '0;
        y_addr = '0; y_wr_n = 1'b1; y_pass_n = 1'b1; y_din = '0;
    endtask

    task automatic drive_vec(input vec_t v);
        sel_lo_n = v.lo_n; sel_hi = v.hi;
        x_addr = v.xa; x_wr_n = v.xw; x_pass_n = v.xp; x_din = v.xd;
        y_addr = v.ya; y_wr_n = v.yw; y_pass_n = v.yp; y_din = v.yd;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: after reset both ports are silent
        check("R12", "x_drive after reset", {35'd0, x_drive}, 36'd0);
        check("R12", "y_drive after reset", {35'd0, y_drive}, 36'd0);
        drive_idle();
        @(posedge clk); @(negedge clk);
        check("R12", "x_drive one edge later", {35'd0, x_drive}, 36'd0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            drive_vec(VEC[i]);
            @(posedge clk); @(negedge clk);
            drive_idle();
            @(posedge clk); @(negedge clk);
            check(tag, $sformatf("vec %0d x_drive", i), {35'd0, x_drive}, {35'd0, VEC[i].ex_v});
            check(tag, $sformatf("vec %0d y_drive", i), {35'd0, y_drive}, {35'd0, VEC[i].ey_v});
            if (VEC[i].ex_v)
                check(tag, $sformatf("vec %0d x_dout", i), x_dout, VEC[i].ex_q);
            if (VEC[i].ey_v)
                check(tag, $sformatf("vec %0d y_dout", i), y_dout, VEC[i].ey_q);
        end

        // R1: write cycle then read cycle back to back; one edge after the
        // read is captured the port still shows the write cycle (silent).
        drive_idle();
        x_addr = 15'd20; x_wr_n = 1'b0; x_din = D1;
        @(posedge clk); @(negedge clk);
        drive_idle();
        x_addr = 15'd20;
        @(posedge clk); @(negedge clk);
        check("R1", "x_drive one edge after read capture", {35'd0, x_drive}, 36'd0);
        drive_idle();
        @(posedge clk); @(negedge clk);
        check("R1", "x_drive two edges after read capture", {35'd0, x_drive}, 36'd1);
        check("R1", "x_dout two edges after read capture", x_dout, D1);

        // R10: output enable acts with no clock edge
        x_oe_n = 1'b1;
        #0.5;
        check("R10", "x_drive with oe high", {35'd0, x_drive}, 36'd0);
        x_oe_n = 1'b0;
        #0.5;
        check("R10", "x_drive with oe low again", {35'd0, x_drive}, 36'd1);

        // R11: a forwarding-out request on Y silences Y itself
        drive_idle();
        y_addr = 15'd20; y_pass_n = 1'b0; y_din = G1;
        @(posedge clk); @(negedge clk);
        drive_idle();
        @(posedge clk); @(negedge clk);
        check("R11", "y_drive while forwarding out", {35'd0, y_drive}, 36'd0);
        check("R5", "x_dout receives forwarded word", x_dout, G1);

        // R12: reset in the middle of traffic clears the drive-enables
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R12", "x_drive after mid-run reset", {35'd0, x_drive}, 36'd0);

        done = 1'b1;
        finish_run();
    end

endmodule